// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple memory-mapped register bus. Accesses use a select, a write enable, a 12-bit byte address and 32-bit data. Read data is combinational, so it is valid in the same cycle as the select. The lowest kilobyte of the address space is a data window. In that window the address itself carries a per-access pin mask in bits [9:2]. Software can therefore set, clear or sample any subset of pins in a single access, with no read-modify-write.

A direction register makes each pin an input or an output. Each output pin drives its stored data bit. Each input pin drives a logic 1, so undriven lines idle high. For an input pin, the data bit tracks the external level through a two-flop synchronizer.

The block also holds the interrupt configuration registers: sense, both-edges, event and mask. It keeps a raw status register, which an external edge detector sets through `intr_raise` and software clears by writing ones. The sense, both-edges and event settings are presented to that detector. A twelve-byte identification area, fixed by a parameter, sits at the top of the address space.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction, data, interrupt configuration, mask and raw status registers are all zero, so every pin is an input and every `pin_out` bit is 1.
- R2: A read at a byte offset below 0x400 returns the pin data register ANDed with the 8-bit mask held in address bits [9:2]. All other bits read as zero.
- R3: A write at a byte offset below 0x400 changes only the data bits whose mask bit (address bits [9:2]) and direction bit are both 1. The new value is taken from write data bits [7:0]. Every other data bit keeps its value.
- R4: The direction register is at offset 0x400, where bit value 1 means output. A write stores write data bits [7:0], and a read returns them zero-extended.
- R5: For an input pin, the data bit equals the `pin_in` level sampled three rising edges earlier (two synchronizer flops, then the data register). An output pin's data bit is unaffected by `pin_in`.
- R6: `pin_out[i]` equals data bit i when direction bit i is 1, and is 1 otherwise.
- R7: The sense (0x404), both-edges (0x408), event (0x40C) and mask (0x410) registers store write data bits [7:0] and read back zero-extended. Sense, both-edges and event also appear on `intr_sense`, `intr_both` and `intr_event`.
- R8: The raw status (read at 0x414) sets each bit i on any rising edge where `intr_raise[i]` is 1. A write to 0x41C clears each bit whose write data bit is 1. When a bit is both raised and cleared in the same cycle, the raise wins.
- R9: A read at 0x418 returns raw status ANDed with the mask register.
- R10: A read at 0xFD0 to 0xFFC returns identification byte (offset − 0xFD0)/4 in bits [7:0]. The bytes, index 0 to 11, are 00 00 00 00 3C 12 08 00 17 42 6E 91 (hex).
- R11: Reads of unmapped offsets, reads of 0x41C, and any cycle without a read select return 0. Writes to unmapped offsets, and write enables without select, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read (with select) |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Pin drive values, 1 on input pins |
| intr_raise | input | 8 | Per-pin raw status set pulses from the edge detector |
| intr_sense | output | 8 | Sense configuration to the edge detector |
| intr_both | output | 8 | Both-edges configuration to the edge detector |
| intr_event | output | 8 | Event polarity configuration to the edge detector |

## Verification
The assertions assume that every address is word aligned. They also assume that `pin_in` and `intr_raise` are settled well before each rising edge, so the sampled value is well defined. The stimulus changes all inputs only on falling clock edges and draws every address from word-aligned offsets. These offsets include the data window, every mapped register, the identification area and a few holes. Because of this, the one-cycle relations the assertions state always see clean, single-valued inputs.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MIS   = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 12'h41C;
  localparam logic [ADDR_W-1:0] OFS_IDLO  = 12'hFD0;

  // index into the configuration register bank of the interrupt unit
  localparam int unsigned CFG_SENSE = 0;
  localparam int unsigned CFG_BOTH  = 1;
  localparam int unsigned CFG_EVENT = 2;
  localparam int unsigned CFG_MASK  = 3;
  localparam int unsigned CFG_NUM   = 4;

  typedef enum logic [3:0] {
    RG_NONE, RG_DATA, RG_DIR, RG_SENSE, RG_BOTH, RG_EVENT,
    RG_MASK, RG_RAW, RG_MIS, RG_ICLR, RG_ID
  } region_e;
endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[0], async_in[g]};
    end
    assign sync_out[g] = stage_q[1];
  end
endmodule

// File: rtl/gpio_mp_data.sv
module gpio_mp_data #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] sync_in,
  input  logic            wr_en,
  input  logic [NPIN-1:0] wr_mask,
  input  logic [NPIN-1:0] wr_data,
  output logic [NPIN-1:0] data_q,
  output logic [NPIN-1:0] pin_out
);
  logic [NPIN-1:0] data_d;
  logic [NPIN-1:0] upd_bits;

  always_comb begin
    upd_bits = wr_en ? (wr_mask & dir) : '0;
    data_d   = (data_q & dir) | (sync_in & ~dir);
    data_d   = (data_d & ~upd_bits) | (wr_data & upd_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_drv
    assign pin_out[g] = dir[g] ? data_q[g] : 1'b1;
  end

  // output bits move only through a window write
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((data_q & $past(dir)) == ($past(data_q) & $past(dir))));

  // input bits copy the synchronizer output one edge later
  assert_in_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q & ~$past(dir)) == ($past(sync_in) & ~$past(dir))));
endmodule

// File: rtl/gpio_mp_irq.sv
module gpio_mp_irq #(
  parameter int unsigned NPIN = 8,
  parameter int unsigned NCFG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCFG-1:0] cfg_we,
  input  logic [NPIN-1:0] wr_data,
  input  logic            clr_en,
  input  logic [NPIN-1:0] raise,
  output logic [NPIN-1:0] cfg_q [NCFG],
  output logic [NPIN-1:0] raw_q
);
  for (genvar r = 0; r < NCFG; r++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[r] <= '0;
      else if (cfg_we[r]) cfg_q[r] <= wr_data;
    end
  end

  logic [NPIN-1:0] clr_bits;
  assign clr_bits = clr_en ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_bits) | raise;
  end

  assert_raise_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(raise)) == $past(raise)));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((raw_q & $past(wr_data) & ~$past(raise)) == '0));
endmodule

// File: rtl/gpio_mp_idrom.sv
module gpio_mp_idrom #(
  parameter int unsigned       ID_COUNT = 12,
  parameter logic [8*ID_COUNT-1:0] ID_VALUE = '0,
  localparam int unsigned      IDX_W    = $clog2(ID_COUNT + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       id_byte
);
  logic [7:0] rom [ID_COUNT];
  for (genvar k = 0; k < ID_COUNT; k++) begin : g_rom
    assign rom[k] = ID_VALUE[8*k +: 8];
  end

  always_comb begin
    id_byte = '0;
    for (int k = 0; k < ID_COUNT; k++) begin
      if (idx == IDX_W'(k)) id_byte = rom[k];
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mp_pkg::*;
#(
  parameter int unsigned NPIN     = 8,
  parameter int unsigned ID_COUNT = 12,
  parameter logic [8*ID_COUNT-1:0] ID_VALUE = 96'h916E4217_0008123C_00000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  input  logic [NPIN-1:0]   intr_raise,
  output logic [NPIN-1:0]   intr_sense,
  output logic [NPIN-1:0]   intr_both,
  output logic [NPIN-1:0]   intr_event
);
  localparam int unsigned IDX_W  = $clog2(ID_COUNT + 1);
  localparam int unsigned WIN_HI = NPIN + 2;  // first address bit above the window

  // ---------------- decode ----------------
  region_e region;
  always_comb begin
    region = RG_NONE;
    if (bus_addr[ADDR_W-1:WIN_HI] == '0) region = RG_DATA;
    else if (bus_addr >= OFS_IDLO)        region = RG_ID;
    else begin
      case (bus_addr)
        OFS_DIR:   region = RG_DIR;
        OFS_SENSE: region = RG_SENSE;
        OFS_BOTH:  region = RG_BOTH;
        OFS_EVENT: region = RG_EVENT;
        OFS_MASK:  region = RG_MASK;
        OFS_RAW:   region = RG_RAW;
        OFS_MIS:   region = RG_MIS;
        OFS_ICLR:  region = RG_ICLR;
        default:   region = RG_NONE;
      endcase
    end
  end

  logic wr_go, rd_go;
  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && !bus_wr;

  logic [NPIN-1:0] acc_mask;
  logic [NPIN-1:0] wr_byte;
  assign acc_mask = bus_addr[WIN_HI-1:2];
  assign wr_byte  = bus_wdata[NPIN-1:0];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:NPIN], bus_addr[1:0]};

  // ---------------- direction ----------------
  logic [NPIN-1:0] dir_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dir_q <= '0;
    else if (wr_go && region == RG_DIR) dir_q <= wr_byte;
  end

  // ---------------- pins ----------------
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] data_q;

  gpio_mp_sync #(.WIDTH(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_mp_data #(.NPIN(NPIN)) u_data (
    .clk(clk), .rst_n(rst_n), .dir(dir_q), .sync_in(pin_sync),
    .wr_en(wr_go && region == RG_DATA), .wr_mask(acc_mask), .wr_data(wr_byte),
    .data_q(data_q), .pin_out(pin_out)
  );

  // ---------------- interrupt registers ----------------
  logic [CFG_NUM-1:0] cfg_we;
  logic [NPIN-1:0]    cfg_q [CFG_NUM];
  logic [NPIN-1:0]    raw_q;

  always_comb begin
    cfg_we            = '0;
    cfg_we[CFG_SENSE] = wr_go && region == RG_SENSE;
    cfg_we[CFG_BOTH]  = wr_go && region == RG_BOTH;
    cfg_we[CFG_EVENT] = wr_go && region == RG_EVENT;
    cfg_we[CFG_MASK]  = wr_go && region == RG_MASK;
  end

  gpio_mp_irq #(.NPIN(NPIN), .NCFG(CFG_NUM)) u_irq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wr_data(wr_byte),
    .clr_en(wr_go && region == RG_ICLR), .raise(intr_raise),
    .cfg_q(cfg_q), .raw_q(raw_q)
  );

  assign intr_sense = cfg_q[CFG_SENSE];
  assign intr_both  = cfg_q[CFG_BOTH];
  assign intr_event = cfg_q[CFG_EVENT];

  // ---------------- identification ----------------
  logic [ADDR_W-1:0] id_off;
  logic [IDX_W-1:0]  id_idx;
  logic [7:0]        id_byte;
  assign id_off = bus_addr - OFS_IDLO;
  assign id_idx = IDX_W'(id_off >> 2);

  gpio_mp_idrom #(.ID_COUNT(ID_COUNT), .ID_VALUE(ID_VALUE)) u_id (
    .idx(id_idx), .id_byte(id_byte)
  );

  // ---------------- read mux ----------------
  logic [NPIN-1:0] rd_val;
  always_comb begin
    case (region)
      RG_DATA:  rd_val = data_q & acc_mask;
      RG_DIR:   rd_val = dir_q;
      RG_SENSE: rd_val = cfg_q[CFG_SENSE];
      RG_BOTH:  rd_val = cfg_q[CFG_BOTH];
      RG_EVENT: rd_val = cfg_q[CFG_EVENT];
      RG_MASK:  rd_val = cfg_q[CFG_MASK];
      RG_RAW:   rd_val = raw_q;
      RG_MIS:   rd_val = raw_q & cfg_q[CFG_MASK];
      RG_ID:    rd_val = NPIN'(id_byte);
      default:  rd_val = '0;
    endcase
  end
  assign bus_rdata = rd_go ? DATA_W'(rd_val) : '0;

  assert_dir_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata[NPIN-1:0])));

  assert_nosel_keeps_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(dir_q));
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0, pin_out, intr_raise = '0;
  logic [7:0]  intr_sense, intr_both, intr_event;

  always #5 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .intr_raise(intr_raise),
    .intr_sense(intr_sense), .intr_both(intr_both), .intr_event(intr_event)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference state
  logic [7:0] m_dir, m_data, m_sen, m_bth, m_evt, m_msk, m_raw, m_s1, m_s2;
  logic [7:0] idb [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h12,
                           8'h08, 8'h00, 8'h17, 8'h42, 8'h6E, 8'h91};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_data = 0; m_sen = 0; m_bth = 0; m_evt = 0;
      m_msk = 0; m_raw = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      logic [7:0] nd, clr, mk;
      nd  = (m_data & m_dir) | (m_s2 & ~m_dir);
      clr = 0;
      if (bus_sel && bus_wr) begin
        if (bus_addr < 12'h400) begin
          mk = bus_addr[9:2] & m_dir;
          nd = (nd & ~mk) | (bus_wdata[7:0] & mk);
        end
        case (bus_addr)
          12'h400: m_dir = bus_wdata[7:0];
          12'h404: m_sen = bus_wdata[7:0];
          12'h408: m_bth = bus_wdata[7:0];
          12'h40C: m_evt = bus_wdata[7:0];
          12'h410: m_msk = bus_wdata[7:0];
          12'h41C: clr   = bus_wdata[7:0];
          default: ;
        endcase
      end
      m_raw  = (m_raw & ~clr) | intr_raise;
      m_data = nd;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a < 12'h400) return {24'h0, m_data & a[9:2]};
    if (a >= 12'hFD0) return {24'h0, idb[(a - 12'hFD0) >> 2]};
    case (a)
      12'h400: return {24'h0, m_dir};
      12'h404: return {24'h0, m_sen};
      12'h408: return {24'h0, m_bth};
      12'h40C: return {24'h0, m_evt};
      12'h410: return {24'h0, m_msk};
      12'h414: return {24'h0, m_raw};
      12'h418: return {24'h0, m_raw & m_msk};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    if (a < 12'h400) return "R2";
    if (a >= 12'hFD0) return "R10";
    case (a)
      12'h400: return "R4";
      12'h404, 12'h408, 12'h40C, 12'h410: return "R7";
      12'h414: return "R8";
      12'h418: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    logic [31:0] exp_rd;
    logic [7:0]  exp_po;
    exp_rd = (bus_sel && !bus_wr) ? model_read(bus_addr) : 32'h0;
    exp_po = (m_data & m_dir) | ~m_dir;
    vectors++;
    if (bus_rdata !== exp_rd) begin
      misses++;
      $display("FAIL %s read @%h: got %h expected %h",
               (bus_sel && !bus_wr) ? req_of(bus_addr) : "R11", bus_addr, bus_rdata, exp_rd);
    end
    if (pin_out !== exp_po) begin
      misses++;
      $display("FAIL R6 pin_out: got %h expected %h", pin_out, exp_po);
    end
    if (intr_sense !== m_sen || intr_both !== m_bth || intr_event !== m_evt) begin
      misses++;
      $display("FAIL R7 cfg outs: got %h/%h/%h expected %h/%h/%h",
               intr_sense, intr_both, intr_event, m_sen, m_bth, m_evt);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [7:0] pins, input logic [7:0] rz);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    pin_in = pins; intr_raise = rz;
    #1 compare();
  endtask

  task automatic rd(input logic [11:0] a);
    drive(1, 0, a, 32'h0, pin_in, 8'h00);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    drive(1, 1, a, d, pin_in, 8'h00);
  endtask

  // explicit latency check for input pins
  task automatic check_pin_latency();
    drive(0, 0, 12'h0, 0, 8'h00, 0);
    drive(0, 0, 12'h0, 0, 8'h00, 0);
    drive(0, 0, 12'h0, 0, 8'h00, 0);
    drive(0, 0, 12'h0, 0, 8'h80, 0);  // pin 7 rises
    for (int k = 0; k < 3; k++) begin
      rd(12'h200);                    // mask bit 7 only
      vectors++;
      if (bus_rdata !== (k == 2 ? 32'h80 : 32'h0)) begin
        misses++;
        $display("FAIL R5 latency step %0d: got %h expected %h",
                 k, bus_rdata, (k == 2 ? 32'h80 : 32'h0));
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 compare();                      // R1 outputs during reset
    rst_n = 1'b1;
    // R1: every register reads zero after reset
    foreach (idb[i]) ;
    rd(12'h3FC); rd(12'h400); rd(12'h404); rd(12'h408); rd(12'h40C);
    rd(12'h410); rd(12'h414); rd(12'h418);
    // R4: direction keeps only the low byte
    wr(12'h400, 32'hFFFF_FF0F); rd(12'h400);
    // R3: full-mask write, outputs only
    wr(12'h3FC, 32'h0000_00A5); rd(12'h3FC); rd(12'h03C); rd(12'h010);
    // R3: partial mask clears bits 0,1 only
    wr(12'h00C, 32'h0); rd(12'h3FC);
    // R3: mask selects input-only bits -> no change
    wr(12'h3C0, 32'hFF); rd(12'h3FC);
    // R5: inputs follow pins, outputs ignore them
    drive(0, 0, 12'h0, 0, 8'hFF, 0); drive(0, 0, 12'h0, 0, 8'hFF, 0);
    drive(0, 0, 12'h0, 0, 8'hFF, 0); rd(12'h3FC);
    drive(0, 0, 12'h0, 0, 8'h3C, 0); drive(0, 0, 12'h0, 0, 8'h3C, 0);
    drive(0, 0, 12'h0, 0, 8'h3C, 0); rd(12'h3FC);
    wr(12'h400, 32'h0); check_pin_latency();
    // R7: configuration registers
    wr(12'h404, 32'h1234_5611); wr(12'h408, 32'h22); wr(12'h40C, 32'h44);
    wr(12'h410, 32'h0F); rd(12'h404); rd(12'h408); rd(12'h40C); rd(12'h410);
    // R8/R9: raise, clear, raise wins over clear
    drive(0, 0, 12'h0, 0, pin_in, 8'h5A); rd(12'h414); rd(12'h418);
    wr(12'h41C, 32'h0000_0042); rd(12'h414);
    drive(1, 1, 12'h41C, 32'hFF, pin_in, 8'h10); rd(12'h414); rd(12'h418);
    // R10: identification bytes
    for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(4 * k));
    // R11: holes, clear register read, unselected write, hole write
    rd(12'h41C); rd(12'h420); rd(12'h800); rd(12'hFCC);
    drive(0, 1, 12'h400, 32'hFF, pin_in, 0); rd(12'h400);
    wr(12'h424, 32'hFF); wr(12'hA00, 32'hFF); rd(12'h400); rd(12'h410);
    // mixed random traffic, reference compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = {2'b00, 8'($urandom), 2'b00};
        3:       a = 12'h400 + 12'(4 * $urandom_range(0, 8));
        4:       a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
        5:       a = 12'h800 + 12'(4 * $urandom_range(0, 64));
        default: a = 12'h400 + 12'(4 * $urandom_range(0, 7));
      endcase
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom,
            8'($urandom), ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule